// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block is the interrupt front end that sits between a microcontroller's I/O pins and its CPU. It serves a small set of dedicated request pins and a larger set of pin-change inputs. Each dedicated pin has an enable bit and a two-bit sense control. Its request can be a low level or an edge. The pin-change inputs are grouped into banks. Each bank has a per-pin mask and one sticky request flag. The CPU clears the edge and pin-change flags by writing ones. The block only looks at the pin value, so a pin driven as an output by software can raise a request. This gives a software interrupt.

The block also forms a combinational wake request for the sleep controller. The wake request is built from enabled low levels and masked pin-change mismatches, so it needs no clock. Edge sensing on the dedicated pins is active only while the I/O clock enable is high. A small power sequencer tracks three states: run, sleep and a programmable start-up delay. While the CPU is not running, level requests are held off. After start-up, a level request reaches the CPU only if the pin is still low.

Top module: `extint_ctrl`

## Requirements
- R1: The sense control of dedicated pin i is `ded_sense[2i+1:2i]`, encoded as 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. In an edge mode, a matching transition on an enabled pin sets that pin's flag. `ded_irq[i]` goes high after the third rising clock edge that follows the pin change. A transition that does not match the mode sets nothing.
- R2: While `ded_en[i]` is 0, pin i never raises `ded_irq[i]`, whatever its sense mode.
- R3: In level mode with the pin enabled and the CPU running, `ded_irq[i]` is high exactly while the synchronized pin is low. It rises two clock edges after the pin falls and drops two edges after the pin rises, with no clear needed.
- R4: An edge flag stays set until a one is written on `ded_clr[i]` for one cycle. That write clears only pin i.
- R5: Dedicated edge sensing works only while `io_clk_en` is 1. A transition made while it is 0 is lost: it is not reported when the enable returns.
- R6: Bank b covers pins `pc_pin[8b+7:8b]`. A toggle on any of those pins whose `pc_mask` bit is 1 sets `pc_irq[b]`, with the same three-edge latency as R1. A toggle on a pin with a clear mask bit has no effect. `pc_irq[b]` stays set until a one is written on `pc_clr[b]`.
- R7: Pin-change flags are set whatever the value of `io_clk_en`.
- R8: `wake_req` is combinational. It is high in the same cycle an enabled level-mode dedicated pin is low. It is also high from the moment a masked pin-change input toggles until that change has passed the synchronizer.
- R9: When `sleep_req` is high while running, `cpu_run` drops at the next clock edge. In sleep, a high `wake_req` starts a start-up phase, and `cpu_run` returns after `startup_len`+1 further edges. With `startup_len` = 0, that means two edges after the wake request.
- R10: Level requests are held low while `cpu_run` is 0. If the level pin has gone high before start-up ends, no request appears. If it is still low, `ded_irq` is high in the first running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock for synchronizers and sequencer |
| rst | input | 1 | Synchronous active-high reset |
| io_clk_en | input | 1 | High while the I/O clock runs; gates dedicated edge sensing |
| ded_pin | input | NUM_DED | Dedicated request pins |
| ded_en | input | NUM_DED | Per-pin enable of dedicated requests |
| ded_sense | input | 2*NUM_DED | Two-bit sense control per dedicated pin |
| ded_clr | input | NUM_DED | Write-one-to-clear pulses for dedicated edge flags |
| ded_irq | output | NUM_DED | Dedicated requests to the CPU |
| pc_pin | input | NUM_BANKS*BANK_W | Pin-change inputs |
| pc_mask | input | NUM_BANKS*BANK_W | Per-pin pin-change mask |
| pc_clr | input | NUM_BANKS | Write-one-to-clear pulses for bank flags |
| pc_irq | output | NUM_BANKS | Pin-change bank requests |
| sleep_req | input | 1 | CPU request to enter sleep |
| startup_len | input | CNT_W | Start-up delay count |
| wake_req | output | 1 | Combinational wake request for the sleep controller |
| cpu_run | output | 1 | High while the CPU is running |

## Verification
The bench builds the block with its default parameters: two dedicated pins, two banks of eight pin-change inputs, and an eight-bit start-up count. Because the start-up length is a port, both the zero-length start-up and a five-cycle start-up can be tested in one build. The five-cycle case leaves room to release the level pin partway through start-up. Using two banks makes it possible to show that a toggle in one bank leaves the other bank's flag clear.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        PWR_RUN     = 2'b00,
        PWR_SLEEP   = 2'b01,
        PWR_STARTUP = 2'b10
    } pwr_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } edge_pair_t;

    function automatic logic edge_hit(input sense_e mode, input edge_pair_t p);
        case (mode)
            SENSE_ANY:  return p.cur ^ p.prev;
            SENSE_FALL: return p.prev & ~p.cur;
            SENSE_RISE: return ~p.prev & p.cur;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/extint_ded_chan.sv
`timescale 1ns/1ps
module extint_ded_chan
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       io_clk_en,
    input  logic       run,
    input  logic       en,
    input  logic [1:0] sense,
    input  logic       pin_raw,
    input  logic       pin_s,
    input  logic       clr,
    output logic       irq,
    output logic       wake
);
    sense_e     mode;
    edge_pair_t pair;
    logic       prev_q;
    logic       flag_q;
    logic       hit;

    assign mode      = sense_e'(sense);
    assign pair.cur  = pin_s;
    assign pair.prev = prev_q;
    assign hit       = en & io_clk_en & edge_hit(mode, pair);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (hit)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign irq  = (mode == SENSE_LOW) ? (en & ~pin_s & run) : flag_q;
    assign wake = en & (mode == SENSE_LOW) & ~pin_raw;

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);
    a_r5_edge_needs_ioclk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(io_clk_en));
    a_r2_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(en));
endmodule

// File: rtl/extint_pc_bank.sv
`timescale 1ns/1ps
module extint_pc_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_raw,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] mask,
    input  logic         clr,
    output logic         flag,
    output logic         wake
);
    logic [W-1:0] prev_q;
    logic [W-1:0] change;

    assign change = (pin_s ^ prev_q) & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag   <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (|change)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    assign wake = |((pin_raw ^ pin_s) & mask);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    a_r6_needs_mask: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(mask != '0));
endmodule

// File: rtl/extint_wake_seq.sv
`timescale 1ns/1ps
module extint_wake_seq
    import extint_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic [CNT_W-1:0] startup_len,
    output logic             run
);
    pwr_e             st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PWR_RUN;
            cnt_q <= '0;
        end else begin
            case (st_q)
                PWR_RUN: if (sleep_req) st_q <= PWR_SLEEP;
                PWR_SLEEP: if (wake_req) begin
                    st_q  <= PWR_STARTUP;
                    cnt_q <= startup_len;
                end
                PWR_STARTUP: begin
                    if (cnt_q == '0) st_q  <= PWR_RUN;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= PWR_RUN;
            endcase
        end
    end

    assign run = (st_q == PWR_RUN);

    a_r9_count_down: assert property (@(posedge clk) disable iff (rst)
        (st_q == PWR_STARTUP && cnt_q != '0) |=> (st_q == PWR_STARTUP && cnt_q == $past(cnt_q) - CNT_W'(1)));
    a_r9_no_skip_startup: assert property (@(posedge clk) disable iff (rst)
        (st_q == PWR_SLEEP) |=> !run);
endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/1ps
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_DED   = 2,
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter int CNT_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        io_clk_en,
    input  logic [NUM_DED-1:0]          ded_pin,
    input  logic [NUM_DED-1:0]          ded_en,
    input  logic [2*NUM_DED-1:0]        ded_sense,
    input  logic [NUM_DED-1:0]          ded_clr,
    output logic [NUM_DED-1:0]          ded_irq,
    input  logic [NUM_BANKS*BANK_W-1:0] pc_pin,
    input  logic [NUM_BANKS*BANK_W-1:0] pc_mask,
    input  logic [NUM_BANKS-1:0]        pc_clr,
    output logic [NUM_BANKS-1:0]        pc_irq,
    input  logic                        sleep_req,
    input  logic [CNT_W-1:0]            startup_len,
    output logic                        wake_req,
    output logic                        cpu_run
);
    localparam int PC_W = NUM_BANKS * BANK_W;

    logic [NUM_DED-1:0]   ded_s;
    logic [NUM_DED-1:0]   ded_wake;
    logic [PC_W-1:0]      pc_s;
    logic [NUM_BANKS-1:0] pc_wake;

    extint_sync #(.W(NUM_DED), .RST_VAL(1'b1)) u_ded_sync (
        .clk(clk), .rst(rst), .d(ded_pin), .q(ded_s)
    );

    extint_sync #(.W(PC_W), .RST_VAL(1'b0)) u_pc_sync (
        .clk(clk), .rst(rst), .d(pc_pin), .q(pc_s)
    );

    for (genvar i = 0; i < NUM_DED; i++) begin : g_ded
        extint_ded_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .io_clk_en (io_clk_en),
            .run       (cpu_run),
            .en        (ded_en[i]),
            .sense     (ded_sense[2*i +: 2]),
            .pin_raw   (ded_pin[i]),
            .pin_s     (ded_s[i]),
            .clr       (ded_clr[i]),
            .irq       (ded_irq[i]),
            .wake      (ded_wake[i])
        );

        a_r10_level_held_off: assert property (@(posedge clk) disable iff (rst)
            (!cpu_run && sense_e'(ded_sense[2*i +: 2]) == SENSE_LOW) |-> !ded_irq[i]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        extint_pc_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .pin_raw (pc_pin[b*BANK_W +: BANK_W]),
            .pin_s   (pc_s[b*BANK_W +: BANK_W]),
            .mask    (pc_mask[b*BANK_W +: BANK_W]),
            .clr     (pc_clr[b]),
            .flag    (pc_irq[b]),
            .wake    (pc_wake[b])
        );
    end

    assign wake_req = (|ded_wake) | (|pc_wake);

    extint_wake_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .sleep_req   (sleep_req),
        .wake_req    (wake_req),
        .startup_len (startup_len),
        .run         (cpu_run)
    );

    a_r9_sleep_entry: assert property (@(posedge clk) disable iff (rst)
        (cpu_run && sleep_req) |=> !cpu_run);
endmodule

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
module extint_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_clk_en;
    logic [1:0]  ded_pin, ded_en, ded_clr, ded_irq;
    logic [3:0]  ded_sense;
    logic [15:0] pc_pin, pc_mask;
    logic [1:0]  pc_clr, pc_irq;
    logic        sleep_req;
    logic [7:0]  startup_len;
    logic        wake_req, cpu_run;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    extint_ctrl u_dut (
        .clk(clk), .rst(rst), .io_clk_en(io_clk_en),
        .ded_pin(ded_pin), .ded_en(ded_en), .ded_sense(ded_sense),
        .ded_clr(ded_clr), .ded_irq(ded_irq),
        .pc_pin(pc_pin), .pc_mask(pc_mask), .pc_clr(pc_clr), .pc_irq(pc_irq),
        .sleep_req(sleep_req), .startup_len(startup_len),
        .wake_req(wake_req), .cpu_run(cpu_run)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive_slot();
        @(negedge clk);
    endtask

    task automatic clear_ded(input int i);
        drive_slot();
        ded_clr[i] = 1'b1;
        edges(1);
        ded_clr[i] = 1'b0;
    endtask

    task automatic clear_pc(input int b);
        drive_slot();
        pc_clr[b] = 1'b1;
        edges(1);
        pc_clr[b] = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 reset cpu_run", cpu_run, 1);
        check("R4 reset ded_irq", ded_irq, 0);
        check("R6 reset pc_irq", pc_irq, 0);
        check("R8 reset wake_req", wake_req, 0);
    endtask

    task automatic t_falling();
        drive_slot();
        ded_sense[1:0] = 2'b10; ded_en[0] = 1'b1;
        drive_slot();
        ded_pin[0] = 1'b0;
        edges(2);
        check("R1 falling not yet", ded_irq[0], 0);
        edges(1);
        check("R1 falling sets flag", ded_irq[0], 1);
        check("R1 other pin quiet", ded_irq[1], 0);
        edges(3);
        check("R4 flag held", ded_irq[0], 1);
        clear_ded(0);
        check("R4 clear by write one", ded_irq[0], 0);
        drive_slot();
        ded_pin[0] = 1'b1;
        edges(4);
        check("R1 rise ignored in falling mode", ded_irq[0], 0);
    endtask

    task automatic t_rising();
        drive_slot();
        ded_sense[3:2] = 2'b11; ded_en[1] = 1'b1;
        drive_slot();
        ded_pin[1] = 1'b0;
        edges(4);
        check("R1 fall ignored in rising mode", ded_irq[1], 0);
        drive_slot();
        ded_pin[1] = 1'b1;
        edges(3);
        check("R1 rising sets flag", ded_irq[1], 1);
        drive_slot();
        ded_clr[0] = 1'b1;
        edges(1);
        ded_clr[0] = 1'b0;
        check("R4 clear of other pin leaves flag", ded_irq[1], 1);
        clear_ded(1);
        check("R4 clear rising flag", ded_irq[1], 0);
    endtask

    task automatic t_any();
        drive_slot();
        ded_sense[1:0] = 2'b01;
        drive_slot();
        ded_pin[0] = 1'b0;
        edges(3);
        check("R1 any-change on fall", ded_irq[0], 1);
        clear_ded(0);
        drive_slot();
        ded_pin[0] = 1'b1;
        edges(3);
        check("R1 any-change on rise", ded_irq[0], 1);
        clear_ded(0);
    endtask

    task automatic t_disabled();
        drive_slot();
        ded_en[1] = 1'b0; ded_sense[3:2] = 2'b01;
        drive_slot();
        ded_pin[1] = 1'b0;
        edges(4);
        check("R2 disabled edge", ded_irq[1], 0);
        drive_slot();
        ded_sense[3:2] = 2'b00;
        edges(2);
        check("R2 disabled level", ded_irq[1], 0);
        check("R2 disabled level no wake", wake_req, 0);
        drive_slot();
        ded_pin[1] = 1'b1;
        edges(3);
    endtask

    task automatic t_level();
        drive_slot();
        ded_sense[1:0] = 2'b00;
        drive_slot();
        ded_pin[0] = 1'b0;
        #1;
        check("R8 level wake immediate", wake_req, 1);
        edges(1);
        check("R3 level after one edge", ded_irq[0], 0);
        edges(1);
        check("R3 level after two edges", ded_irq[0], 1);
        drive_slot();
        ded_pin[0] = 1'b1;
        #1;
        check("R8 wake drops with level", wake_req, 0);
        edges(2);
        check("R3 level not latched", ded_irq[0], 0);
    endtask

    task automatic t_ioclk();
        drive_slot();
        ded_en[1] = 1'b1; ded_sense[3:2] = 2'b10; io_clk_en = 1'b0;
        drive_slot();
        ded_pin[1] = 1'b0;
        edges(4);
        check("R5 no edge without io clock", ded_irq[1], 0);
        drive_slot();
        io_clk_en = 1'b1;
        edges(4);
        check("R5 lost edge not reported", ded_irq[1], 0);
        drive_slot();
        io_clk_en = 1'b0;
        ded_pin[1] = 1'b1;
        edges(4);
        drive_slot();
        io_clk_en = 1'b1;
        ded_pin[1] = 1'b0;
        edges(3);
        check("R5 edge with io clock", ded_irq[1], 1);
        clear_ded(1);
        drive_slot();
        ded_en[1] = 1'b0;
        ded_pin[1] = 1'b1;
        edges(3);
    endtask

    task automatic t_pinchange();
        drive_slot();
        pc_mask = 16'h1010;
        drive_slot();
        pc_pin[5] = 1'b1;
        #1;
        check("R8 unmasked toggle no wake", wake_req, 0);
        edges(4);
        check("R6 unmasked toggle ignored", pc_irq, 2'b00);
        drive_slot();
        pc_pin[4] = 1'b1;
        edges(2);
        check("R6 bank0 not yet", pc_irq[0], 0);
        edges(1);
        check("R6 bank0 masked toggle", pc_irq, 2'b01);
        clear_pc(0);
        check("R6 bank0 cleared", pc_irq[0], 0);
        drive_slot();
        pc_pin[12] = 1'b1;
        edges(3);
        check("R6 bank1 masked toggle", pc_irq, 2'b10);
        clear_pc(1);
        check("R6 bank1 cleared", pc_irq[1], 0);
    endtask

    task automatic t_pc_noclk();
        drive_slot();
        io_clk_en = 1'b0; pc_mask = 16'h0001;
        drive_slot();
        pc_pin[0] = 1'b1;
        #1;
        check("R8 pin-change wake immediate", wake_req, 1);
        edges(2);
        check("R8 pin-change wake ends after sync", wake_req, 0);
        edges(1);
        check("R7 pin-change without io clock", pc_irq[0], 1);
        clear_pc(0);
        drive_slot();
        io_clk_en = 1'b1;
    endtask

    task automatic enter_sleep();
        drive_slot();
        sleep_req = 1'b1;
        edges(1);
        drive_slot();
        sleep_req = 1'b0;
        check("R9 sleep entry", cpu_run, 0);
    endtask

    task automatic t_sleep_hold();
        drive_slot();
        ded_en[0] = 1'b1; ded_sense[1:0] = 2'b00; startup_len = 8'd5; pc_mask = 16'h0000;
        enter_sleep();
        drive_slot();
        ded_pin[0] = 1'b0;
        edges(2);
        check("R10 level held off in startup", ded_irq[0], 0);
        edges(4);
        check("R9 still starting after len edges", cpu_run, 0);
        edges(1);
        check("R9 run after len+1 edges", cpu_run, 1);
        check("R10 level kept reaches cpu", ded_irq[0], 1);
        drive_slot();
        ded_pin[0] = 1'b1;
        edges(3);
    endtask

    task automatic t_sleep_drop();
        enter_sleep();
        drive_slot();
        ded_pin[0] = 1'b0;
        edges(2);
        drive_slot();
        ded_pin[0] = 1'b1;
        edges(5);
        check("R9 run after drop startup", cpu_run, 1);
        check("R10 level gone no request", ded_irq[0], 0);
    endtask

    task automatic t_sleep_zero();
        drive_slot();
        startup_len = 8'd0; pc_mask = 16'h0100;
        enter_sleep();
        drive_slot();
        pc_pin[8] = 1'b1;
        edges(1);
        check("R9 zero-length startup not yet", cpu_run, 0);
        edges(1);
        check("R9 zero-length startup run", cpu_run, 1);
        edges(1);
        check("R7 pin-change flag set during sleep", pc_irq[1], 1);
        clear_pc(1);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; io_clk_en = 1'b1;
        ded_pin = 2'b11; ded_en = 2'b00; ded_sense = 4'b1010; ded_clr = 2'b00;
        pc_pin = 16'h0000; pc_mask = 16'h0000; pc_clr = 2'b00;
        sleep_req = 1'b0; startup_len = 8'd0;
        edges(3);
        drive_slot();
        rst = 1'b0;
        edges(1);
        t_reset();
        t_falling();
        t_rising();
        t_any();
        t_disabled();
        t_level();
        t_ioclk();
        t_pinchange();
        t_pc_noclk();
        t_sleep_hold();
        t_sleep_drop();
        t_sleep_zero();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule